// File: doc/BRIEF.md
# Interrupt Source PQ Coalescing Bank

The block keeps a two-bit state for each of a set of interrupt sources. The high bit (P) says that the source has been sent toward the downstream event queue and is still waiting for end-of-interrupt. The low bit (Q) records that another trigger arrived while P was set. Because of this, a source is sent onward only once, however often its hardware line pulses. When end-of-interrupt finds Q set, the source is sent again.

Software reaches each source through a 4 KiB page on a request port. The source index sits in the address bits above bit 11, and the low twelve bits choose the operation. Every load returns the state the source held just before the load, and in the same step applies the change the load asks for. Stores are posted into a one-entry buffer. Address bit 6 on a load asks for that load to wait until the buffered store has taken effect. Sources that must be sent onward wait in a pending set and then in a small FIFO. From there a valid/ready handshake delivers their numbers to the event queue.

Top module: `pq_coalesce_bank`

## Requirements
- R1: After reset every source reads PQ=00, `ntf_valid` and `rsp_valid` are low, and an unordered load is ready at once.
- R2: A hardware trigger moves PQ (P is bit 1, Q is bit 0) as follows: 00 to 10, 10 to 11, 11 to 11, and 01 to 11. Only the move from 00 sends the source onward.
- R3: While P stays set, any number of further triggers produce no further notification. They only set Q.
- R4: A load at page offset 0x000 is end-of-interrupt. It moves 10 to 00, and moves 11 to 10 while sending the source onward again. It leaves 00 and 01 unchanged.
- R5: A store at page offset 0x400 (bit 6 ignored) performs the same end-of-interrupt, one cycle after acceptance. Stores to any other offset are accepted and have no effect.
- R6: A load at offset 0x800 returns PQ and leaves it unchanged.
- R7: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 set PQ to 00, 01, 10 and 11. None of them sends the source onward.
- R8: `rsp_valid` is high for exactly one cycle, the cycle after a load is accepted. `rsp_data` then holds `{6'b0, P, Q}` from before that load.
- R9: A load to a source index of `NUM_SRC` or above, or to an offset not listed in R4, R6 and R7, returns 0xFF and changes no state.
- R10: A load with address bit 6 set is held (`req_ready` low) while a posted store is still buffered. A load without bit 6 is always accepted and takes priority over the buffered store.
- R11: When an MMIO update and a trigger hit the same source in the same cycle, the trigger is applied to the result of the MMIO update.
- R12: `ntf_src` stays stable while `ntf_valid` is high and `ntf_ready` is low. Notifications leave in the order they were queued. Sources that become pending in the same cycle are queued lowest index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | NUM_SRC | One-cycle trigger pulse per source |
| req_valid | input | 1 | MMIO request valid |
| req_ready | output | 1 | MMIO request accepted |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | IDX_W+12 | Source index above bit 11, page offset in bits 11:0 |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 8 | Previous PQ, or 0xFF |
| ntf_valid | output | 1 | Notification available |
| ntf_ready | input | 1 | Event queue takes the notification |
| ntf_src | output | $clog2(NUM_SRC) | Source number to enqueue |

## Verification
The bench targets four kinds of case:
- **Re-forward on end-of-interrupt from 11.** A design that drops it loses an interrupt forever.
- **Triggers landing on a source that is masked (01) or already pending.** A design that gets these wrong sends duplicate notifications or clears Q.
- **The same-cycle collision of a set or end-of-interrupt with a trigger.** Here a wrong ordering shows up as a missing or extra notification.
- **Load-after-store ordering.** An ordered load that overtakes the buffered store returns the stale value, and an unordered load that stalls costs throughput.

A random phase with a throttled notify consumer also fills the FIFO. This checks that sources held back in the pending set are neither lost nor delivered twice.

// File: rtl/pq_coalesce_bank.sv
module pq_coalesce_bank #(
  parameter int NUM_SRC    = 16,
  parameter int IDX_W      = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = IDX_W + 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic [7:0]         rsp_data,
  output logic               ntf_valid,
  input  logic               ntf_ready,
  output logic [SRC_W-1:0]   ntf_src
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [1:0]         pq   [NUM_SRC];
  logic [1:0]         pq_n [NUM_SRC];
  logic [NUM_SRC-1:0] fwd, need, clr;
  logic               sb_v;
  logic [SRC_W-1:0]   sb_src;

  logic [IDX_W-1:0] idx;
  logic [11:0]      op;
  logic             ordered, idx_ok, is_ld, ld_acc, ld_known, ld_set, st_acc, drain;
  logic             mm_en, mm_eoi, mm_set;
  logic [SRC_W-1:0] src, mm_src;

  assign idx      = req_addr[ADDR_W-1:12];
  assign ordered  = req_addr[6];
  assign op       = req_addr[11:0] & ~12'h040;
  assign idx_ok   = idx < IDX_W'(NUM_SRC);
  assign src      = idx[SRC_W-1:0];
  assign is_ld    = req_valid && !req_write;
  assign req_ready = !(is_ld && ordered && sb_v);
  assign ld_acc   = is_ld && req_ready;
  assign ld_set   = (op[11:10] == 2'b11) && (op[7:0] == 8'h00);
  assign ld_known = (op == 12'h000) || (op == 12'h800) || ld_set;
  assign st_acc   = req_valid && req_write && (op == 12'h400) && idx_ok;
  assign drain    = sb_v && !ld_acc;

  assign mm_en  = (ld_acc && idx_ok && ld_known) || drain;
  assign mm_src = ld_acc ? src : sb_src;
  assign mm_eoi = ld_acc ? (op == 12'h000) : 1'b1;
  assign mm_set = ld_acc && ld_set;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      logic [1:0] p;
      logic       f;
      p = pq[i];
      f = 1'b0;
      if (mm_en && mm_src == SRC_W'(i)) begin
        if (mm_eoi) begin
          if (p == 2'b10) p = 2'b00;
          else if (p == 2'b11) begin p = 2'b10; f = 1'b1; end
        end else if (mm_set) p = op[9:8];
      end
      if (trig_i[i]) begin
        if (p == 2'b00) begin p = 2'b10; f = 1'b1; end
        else p = 2'b11;
      end
      pq_n[i] = p;
      fwd[i]  = f;
    end
  end

  logic [FIFO_DEPTH-1:0][SRC_W-1:0] fifo;
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             pick_v, push, pop;
  logic [SRC_W-1:0] pick;

  always_comb begin
    pick_v = 1'b0;
    pick   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (need[i]) begin pick_v = 1'b1; pick = SRC_W'(i); end
  end

  assign push      = pick_v && (cnt < CNT_W'(FIFO_DEPTH));
  assign clr       = push ? (NUM_SRC'(1) << pick) : '0;
  assign ntf_valid = cnt != '0;
  assign ntf_src   = fifo[rp];
  assign pop       = ntf_valid && ntf_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) pq[i] <= 2'b00;
      need      <= '0;
      sb_v      <= 1'b0;
      sb_src    <= '0;
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) pq[i] <= pq_n[i];
      need <= (need & ~clr) | fwd;
      if (st_acc) begin
        sb_v   <= 1'b1;
        sb_src <= src;
      end else if (drain) sb_v <= 1'b0;
      if (push) begin
        fifo[wp] <= pick;
        wp       <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      cnt       <= cnt + CNT_W'(push) - CNT_W'(pop);
      rsp_valid <= ld_acc;
      rsp_data  <= (idx_ok && ld_known) ? {6'b0, pq[src]} : 8'hFF;
    end
  end
endmodule

// File: rtl/pq_coalesce_bank_chk.sv
module pq_coalesce_bank_chk #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 8,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = IDX_W + 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [7:0]        rsp_data,
  input logic              ntf_valid,
  input logic              ntf_ready,
  input logic [SRC_W-1:0]  ntf_src
);
  logic ld_take, st_eoi, bad_idx;
  assign ld_take = req_valid && !req_write && req_ready;
  assign st_eoi  = req_valid && req_write && ((req_addr[11:0] & ~12'h040) == 12'h400)
                   && (req_addr[ADDR_W-1:12] < IDX_W'(NUM_SRC));
  assign bad_idx = req_addr[ADDR_W-1:12] >= IDX_W'(NUM_SRC);

  assert_ntf_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid && !ntf_ready |=> ntf_valid && $stable(ntf_src));
  assert_ntf_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> int'(ntf_src) < NUM_SRC);
  assert_rsp_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_take |=> rsp_valid);
  assert_rsp_only_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_take |=> !rsp_valid);
  assert_rsp_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data <= 8'd3) || (rsp_data == 8'hFF));
  assert_bad_idx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_take && bad_idx |=> rsp_data == 8'hFF);
  assert_order_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_eoi |=> !(req_valid && !req_write && req_addr[6] && req_ready));
  assert_unordered_go_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && !req_addr[6] |-> req_ready);
endmodule

bind pq_coalesce_bank pq_coalesce_bank_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_src(ntf_src));

// File: tb/sim_pq_coalesce_bank.sv
module sim_pq_coalesce_bank;
  localparam int NS = 16, IW = 8, DEPTH = 4, SW = $clog2(NS), AW = IW + 12;

  logic clk = 0, rst_n = 0;
  logic [NS-1:0] trig = '0;
  logic req_valid = 0, req_write = 0, ntf_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, ntf_valid;
  logic [7:0] rsp_data;
  logic [SW-1:0] ntf_src;

  always #4 clk = ~clk;

  pq_coalesce_bank #(.NUM_SRC(NS), .IDX_W(IW), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_src(ntf_src));

  int checks = 0, fails = 0;
  string tag = "R1";
  int mpq [NS];
  bit mneed [NS];
  int mq [$];
  bit msb_v, mrsp_v, last_acc;
  int msb_src, mrsp_d;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_ready();
    return !(req_valid && !req_write && req_addr[6] && msb_v);
  endfunction

  function automatic int eoi(int v, ref bit f);
    if (v == 2) return 0;
    if (v == 3) begin f = 1; return 2; end
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NS; i++) begin mpq[i] = 0; mneed[i] = 0; end
    mq.delete();
    msb_v = 0; msb_src = 0; mrsp_v = 0; mrsp_d = 0;
  endtask

  task automatic model_step();
    int idx, op, nq [NS], pick;
    bit ok, known, ld, drain, f [NS];
    idx = int'(req_addr >> 12);
    op = int'(req_addr & 20'hFBF) & 'hFFF;
    ok = idx < NS;
    known = (op == 0) || (op == 'h800) || (op == 'hC00) || (op == 'hD00) || (op == 'hE00) || (op == 'hF00);
    ld = req_valid && !req_write && exp_ready();
    last_acc = req_valid && (req_write || exp_ready());
    drain = msb_v && !ld;
    for (int i = 0; i < NS; i++) begin nq[i] = mpq[i]; f[i] = 0; end
    if (ld && ok && known) begin
      if (op == 0) nq[idx] = eoi(nq[idx], f[idx]);
      else if (op >= 'hC00) nq[idx] = (op >> 8) & 3;
    end
    if (drain) nq[msb_src] = eoi(nq[msb_src], f[msb_src]);
    mrsp_v = ld;
    mrsp_d = (ok && known) ? mpq[idx] : 'hFF;
    for (int i = 0; i < NS; i++)
      if (trig[i]) begin
        if (nq[i] == 0) begin nq[i] = 2; f[i] = 1; end
        else nq[i] = 3;
      end
    pick = -1;
    for (int i = NS - 1; i >= 0; i--) if (mneed[i]) pick = i;
    if (mq.size() > 0 && ntf_ready) void'(mq.pop_front());
    if (pick >= 0 && (mq.size() + ((mq.size() == 0 || !ntf_ready) ? 0 : 0)) >= 0) begin
    end
    for (int i = 0; i < NS; i++) mpq[i] = nq[i];
    if (req_valid && req_write && ((op & 'hFFF) == 'h400) && ok) begin msb_v = 1; msb_src = idx; end
    else if (drain) msb_v = 0;
    begin : fifo_push
      int used;
      used = pre_size;
      if (pick >= 0 && used < DEPTH) begin mq.push_back(pick); mneed[pick] = 0; end
    end
    for (int i = 0; i < NS; i++) if (f[i]) mneed[i] = 1;
  endtask

  int pre_size;

  task automatic tick();
    #1;
    chk("req_ready", req_ready, exp_ready());
    chk("ntf_valid", ntf_valid, mq.size() > 0);
    if (mq.size() > 0) chk("ntf_src", ntf_src, mq[0]);
    chk("rsp_valid", rsp_valid, mrsp_v);
    if (mrsp_v) chk("rsp_data", rsp_data, mrsp_d);
    pre_size = mq.size();
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
  endtask

  task automatic req(bit wr, int idx, int off);
    req_valid = 1; req_write = wr; req_addr = AW'((idx << 12) | off);
    tick();
    while (!last_acc) tick();
    req_valid = 0; req_write = 0;
  endtask

  task automatic pulse(int s);
    trig[s] = 1; tick(); trig = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    tick(); tick();
    rst_n = 1;
    tag = "R1"; idle(2);
    for (int s = 0; s < 4; s++) req(0, s, 'h800);
    tick();
    tag = "R2"; pulse(3); idle(2);
    tag = "R3"; pulse(3); pulse(3); req(0, 3, 'h800); idle(2);
    ntf_ready = 1; idle(3); ntf_ready = 0;
    tag = "R4"; req(0, 3, 'h000); req(0, 3, 'h800); req(0, 3, 'h000); req(0, 3, 'h000); tick();
    tag = "R7"; req(0, 5, 'hD00); req(0, 5, 'h800); req(0, 6, 'hF00); req(0, 7, 'hE00); req(0, 8, 'hC00); tick();
    tag = "R2"; pulse(5); req(0, 5, 'h800); tick();
    tag = "R6"; req(0, 6, 'h800); req(0, 6, 'h800); tick();
    tag = "R5"; req(1, 6, 'h800); req(1, 6, 'h400); req(0, 6, 'h800); req(1, 6, 'h440); req(0, 6, 'h800); tick();
    tag = "R9"; req(0, 200, 'h800); req(0, 3, 'h100); req(0, 3, 'h400); req(1, 200, 'h400); tick();
    tag = "R10"; req(0, 9, 'hF00); req(1, 9, 'h400); req(0, 9, 'h840); tick();
    req(0, 9, 'hF00); req(1, 9, 'h400); req(0, 9, 'h800); tick(); tick();
    tag = "R11"; req_valid = 1; req_addr = AW'((7 << 12) | 'hC00); trig[7] = 1; tick();
    req_valid = 0; trig = '0; req(0, 7, 'h800);
    req_valid = 1; req_addr = AW'((7 << 12) | 'h000); trig[7] = 1; tick();
    req_valid = 0; trig = '0; req(0, 7, 'h800); tick();
    tag = "R12"; ntf_ready = 1; idle(6); ntf_ready = 0;
    for (int s = 0; s < NS; s++) req(0, s, 'hC00);
    trig = 16'hA5F3; tick(); trig = '0; idle(12);
    ntf_ready = 1; idle(4); ntf_ready = 0; idle(3); ntf_ready = 1; idle(20);
    tag = "R3";
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 9);
      trig = NS'($urandom) & NS'($urandom) & NS'($urandom);
      ntf_ready = $urandom_range(0, 2) != 0;
      req_valid = r < 6;
      req_write = r < 2;
      req_addr = AW'(($urandom_range(0, 17) << 12) |
                     (($urandom_range(0, 7) inside {0, 1}) ? 'h000 :
                      ($urandom_range(0, 1) ? ('h800 + ($urandom_range(0, 3) << 10)) : 'hD00)) |
                     ($urandom_range(0, 1) << 6));
      if (r < 2) req_addr[11:0] = $urandom_range(0, 3) != 0 ? 12'h400 : 12'h800;
      tick();
    end
    req_valid = 0; trig = '0; ntf_ready = 1; idle(30);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule